// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs memory read and write cycles on a processor bus whose lower lines carry both address and data, and whose upper four lines carry address and then status. Each cycle has four bus states, T1 to T4. The block runs on a clock at twice the bus rate, so each bus state lasts two clock cycles: a first half (A) and a second half (B). The half-phases let the block place edges such as "late in T2" and "early in T4" exactly. The block drives all the memory control pins:

- the address-latch strobe;
- the memory/IO select;
- the transmit/receive direction;
- the active-low read, write and data-enable strobes;
- the active-low bank-high enable;
- the output enable for the shared lines.

The requester uses a valid/ready request port to hand over the operation, the 20-bit address, a byte-high flag, a four-bit status nibble and the write data. A request transfers on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle or in the last half-phase of T4. While `req_ready` is low, the requester must hold `req_valid` and all request fields steady.

Completion is a one-cycle `cyc_done` pulse. Read data is returned on `rd_data`, which stays valid until the next read completes. The completion side has no back-pressure: the requester must take `cyc_done` when it comes.

Slow memory holds `bus_ready` low to stretch the cycle. While it is low, wait states are inserted after T3 and every pin holds its value.

Top module: `bus_cycle_seq`

## Requirements
- R1: An accepted request produces the half-phase order T1A, T1B, T2A, T2B, T3A, T3B, then zero or more wait pairs, then T4A, T4B, with one clock per half-phase. With no waits a cycle lasts 8 clocks, and `cyc_done` is high only in T4B.
- R2: `ale` is 1 only in T1A. In both halves of T1, `ad_oe` is 1 and `ad_out` carries address bits 15:0. `bhe_n` is 0 during T1 when the byte-high flag is set, and is 1 at all other times.
- R3: `m_io` is 1 from T1A through T4B and 0 when idle. `dt_r` is 1 for a write and 0 for a read, and holds steady for the whole cycle.
- R4: In T1, `ahi_out` carries address bits 19:16. From T2A to the end of the cycle it carries the status nibble of the request.
- R5: On a read, `ad_oe` is 0 from T2A to the end of the cycle. `rd_n` and `den_n` are 0 from T2B through T3B and any wait states, and are 1 in T4.
- R6: Read data is captured from `ad_in` on the clock edge at which `bus_ready` is seen high at the end of T3B or of a wait state. It appears on `rd_data` with `cyc_done`, and `rd_data` stays unchanged until the next read completes. A write leaves it unchanged.
- R7: On a write, `wr_n` is 0 from T2A through T3B and any wait states, and is 1 in T4. `ad_oe` is 0 in T2A, and is 1 with `ad_out` carrying the write data from T2B through T4B. `den_n` is 0 from T2B through T4A.
- R8: `bus_ready` low at the end of T3B, or at the end of the second half of a wait state, adds a further two-clock wait state. During wait states the strobes, the data and the status all hold.
- R9: `req_ready` is 1 only when idle or in T4B. A request accepted in T4B is followed at once by T1A, with no idle clock between cycles.
- R10: An active-low asynchronous reset returns the block to idle at once, even in the middle of a cycle. In idle, `ale`, `m_io`, `dt_r` and `ad_oe` are 0; `rd_n`, `wr_n`, `den_n` and `bhe_n` are 1; and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus state rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 20 | Byte address of the cycle |
| req_bhe | input | 1 | High byte lane accessed |
| req_status | input | 4 | Status nibble placed on the upper lines after T1 |
| req_wdata | input | 16 | Write data |
| bus_ready | input | 1 | Memory ready; low inserts wait states |
| ad_in | input | 16 | Value read back from the shared lines |
| ale | output | 1 | Address-latch strobe, active high |
| m_io | output | 1 | Memory/IO select, 1 for memory |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data transceiver enable, active low |
| bhe_n | output | 1 | Bank-high enable, active low |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_out | output | 16 | Value driven on the lower shared lines |
| ahi_out | output | 4 | Value driven on the upper four lines |
| cyc_done | output | 1 | One-clock pulse when a cycle completes |
| rd_data | output | 16 | Data captured by the last read |

## Verification
The bench checks every pin on every half-phase. It does this for reads and writes, with 0, 1, 2 and 3 wait states, with the byte-high flag set and clear, and with the address at all zeros, all ones and mixed values.

Some cycles are issued back to back and others after an idle clock. These two cases separate a correct accept in T4B from an extra turnaround clock.

`ad_in` carries the correct read value only on the one clock where `bus_ready` is seen high, and carries its complement on every other clock. This exposes data captured too early, too late or during a wait state.

Writes placed between reads show that `rd_data` holds its value. A reset applied in T2 of a read shows that the strobes are released at once.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Half-phase of the bus cycle; every bus state spans an A and a B half.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_T1A, PH_T1B,
    PH_T2A, PH_T2B,
    PH_T3A, PH_T3B,
    PH_TWA, PH_TWB,
    PH_T4A, PH_T4B
  } phase_e;

  function automatic logic ph_active(phase_e p);
    return p != PH_IDLE;
  endfunction

  function automatic logic ph_addr(phase_e p);
    return (p == PH_T1A) || (p == PH_T1B);
  endfunction

  // Span from the second half of T2 through the last wait half.
  function automatic logic ph_xfer(phase_e p);
    return p inside {PH_T2B, PH_T3A, PH_T3B, PH_TWA, PH_TWB};
  endfunction

  // Half-phases at which the ready line is sampled.
  function automatic logic ph_ready_pt(phase_e p);
    return (p == PH_T3B) || (p == PH_TWB);
  endfunction

endpackage

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
  import bcs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   ready,
  output phase_e phase,
  output logic   capture,
  output logic   accept_ok
);

  phase_e nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: nxt = start ? PH_T1A : PH_IDLE;
      PH_T1A:  nxt = PH_T1B;
      PH_T1B:  nxt = PH_T2A;
      PH_T2A:  nxt = PH_T2B;
      PH_T2B:  nxt = PH_T3A;
      PH_T3A:  nxt = PH_T3B;
      PH_T3B:  nxt = ready ? PH_T4A : PH_TWA;
      PH_TWA:  nxt = PH_TWB;
      PH_TWB:  nxt = ready ? PH_T4A : PH_TWA;
      PH_T4A:  nxt = PH_T4B;
      PH_T4B:  nxt = start ? PH_T1A : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  assign capture   = ph_ready_pt(phase) && ready;
  assign accept_ok = (phase == PH_IDLE) || (phase == PH_T4B);

  // R1
  t1_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1A) |=> (phase == PH_T1B));

  // R8
  wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_ready_pt(phase) && !ready) |=> (phase == PH_TWA));

  // R8
  wait_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_ready_pt(phase) && ready) |=> (phase == PH_T4A));

endmodule

// File: rtl/bcs_req_hold.sv
module bcs_req_hold #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int STAT_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_wr,
  input  logic              in_bhe,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [STAT_W-1:0] in_stat,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              hd_wr,
  output logic              hd_bhe,
  output logic [ADDR_W-1:0] hd_addr,
  output logic [STAT_W-1:0] hd_stat,
  output logic [DATA_W-1:0] hd_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_wr    <= 1'b0;
      hd_bhe   <= 1'b0;
      hd_addr  <= '0;
      hd_stat  <= '0;
      hd_wdata <= '0;
    end else if (load) begin
      hd_wr    <= in_wr;
      hd_bhe   <= in_bhe;
      hd_addr  <= in_addr;
      hd_stat  <= in_stat;
      hd_wdata <= in_wdata;
    end
  end

endmodule

// File: rtl/bcs_pin_drive.sv
module bcs_pin_drive
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int STAT_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              wr,
  input  logic              bhe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STAT_W-1:0] stat,
  input  logic [DATA_W-1:0] wdata,
  output logic              ale,
  output logic              m_io,
  output logic              dt_r,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              bhe_n,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic [STAT_W-1:0] ahi_out
);

  logic act, in_t1, xfer, wdrive;

  always_comb begin
    act    = ph_active(phase);
    in_t1  = ph_addr(phase);
    xfer   = ph_xfer(phase);
    wdrive = wr && (xfer || phase == PH_T4A || phase == PH_T4B);

    ale    = (phase == PH_T1A);
    m_io   = act;
    dt_r   = act && wr;
    bhe_n  = !(in_t1 && bhe);
    rd_n   = !(!wr && xfer);
    wr_n   = !(wr && (xfer || phase == PH_T2A));
    den_n  = !(xfer || (wr && phase == PH_T4A));
    ad_oe  = in_t1 || wdrive;

    if (in_t1)       ad_out = addr[DATA_W-1:0];
    else if (wdrive) ad_out = wdata;
    else             ad_out = '0;

    if (in_t1)       ahi_out = addr[ADDR_W-1:DATA_W];
    else if (act)    ahi_out = stat;
    else             ahi_out = '0;
  end

  // R5
  rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_n && !ad_oe && !dt_r));

  // R2
  ale_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && m_io));

  // R7
  wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (dt_r && rd_n));

endmodule

// File: rtl/bcs_rdata_cap.sv
module bcs_rdata_cap #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              is_read,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdata <= '0;
    else if (capture && is_read) rdata <= ad_in;
  end

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int STAT_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bhe,
  input  logic [STAT_W-1:0] req_status,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              m_io,
  output logic              dt_r,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              bhe_n,
  output logic              ad_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic [STAT_W-1:0] ahi_out,
  output logic              cyc_done,
  output logic [DATA_W-1:0] rd_data
);

  phase_e            phase;
  logic              capture, accept_ok, start;
  logic              hd_wr, hd_bhe;
  logic [ADDR_W-1:0] hd_addr;
  logic [STAT_W-1:0] hd_stat;
  logic [DATA_W-1:0] hd_wdata;

  assign req_ready = accept_ok;
  assign start     = req_valid && accept_ok;
  assign cyc_done  = (phase == PH_T4B);

  bcs_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (bus_ready),
    .phase     (phase),
    .capture   (capture),
    .accept_ok (accept_ok)
  );

  bcs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .in_wr    (req_write),
    .in_bhe   (req_bhe),
    .in_addr  (req_addr),
    .in_stat  (req_status),
    .in_wdata (req_wdata),
    .hd_wr    (hd_wr),
    .hd_bhe   (hd_bhe),
    .hd_addr  (hd_addr),
    .hd_stat  (hd_stat),
    .hd_wdata (hd_wdata)
  );

  bcs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .wr      (hd_wr),
    .bhe     (hd_bhe),
    .addr    (hd_addr),
    .stat    (hd_stat),
    .wdata   (hd_wdata),
    .ale     (ale),
    .m_io    (m_io),
    .dt_r    (dt_r),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .den_n   (den_n),
    .bhe_n   (bhe_n),
    .ad_oe   (ad_oe),
    .ad_out  (ad_out),
    .ahi_out (ahi_out)
  );

  bcs_rdata_cap #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .is_read (!hd_wr),
    .ad_in   (ad_in),
    .rdata   (rd_data)
  );

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ale);

  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_io && !cyc_done) |=> (m_io && $stable(dt_r)));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);

endmodule

// File: tb/tb_bus_cycle_seq.sv
module tb_bus_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_bhe = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_status = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic        bus_ready = 1'b1;
  logic        req_ready, ale, m_io, dt_r, rd_n, wr_n, den_n, bhe_n, ad_oe, cyc_done;
  logic [15:0] ad_out, rd_data;
  logic [3:0]  ahi_out;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [15:0] last_rd = '0;

  always #10 clk = ~clk;

  bus_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_bhe(req_bhe),
    .req_status(req_status), .req_wdata(req_wdata), .bus_ready(bus_ready),
    .ad_in(ad_in), .ale(ale), .m_io(m_io), .dt_r(dt_r), .rd_n(rd_n),
    .wr_n(wr_n), .den_n(den_n), .bhe_n(bhe_n), .ad_oe(ad_oe),
    .ad_out(ad_out), .ahi_out(ahi_out), .cyc_done(cyc_done), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        wr;
    logic        gap;
    logic [2:0]  waits;
    logic        bhe;
    logic [19:0] addr;
    logic [3:0]  stat;
    logic [15:0] wdata;
    logic [15:0] rdata;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    {1'b0, 1'b1, 3'd0, 1'b1, 20'h12345, 4'h3, 16'h0000, 16'hBEEF},
    {1'b1, 1'b0, 3'd0, 1'b0, 20'hA0F0E, 4'h5, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 3'd2, 1'b0, 20'hFFFFF, 4'hA, 16'h0000, 16'h0F0F},
    {1'b1, 1'b1, 3'd1, 1'b1, 20'h00001, 4'h0, 16'hFFFF, 16'h0000},
    {1'b0, 1'b0, 3'd1, 1'b1, 20'h80000, 4'hF, 16'h0000, 16'h5A5A},
    {1'b1, 1'b1, 3'd3, 1'b0, 20'h7FFFF, 4'h6, 16'h8001, 16'h0000},
    {1'b0, 1'b0, 3'd0, 1'b0, 20'h00000, 4'h9, 16'h0000, 16'hC33C},
    {1'b1, 1'b1, 3'd0, 1'b1, 20'h54321, 4'hC, 16'hA5A5, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R10 ale"},  ale, 0);
    chk({tag, " R3 m_io"},  m_io, 0);
    chk({tag, " R10 dt_r"}, dt_r, 0);
    chk({tag, " R10 rd_n"}, rd_n, 1);
    chk({tag, " R10 wr_n"}, wr_n, 1);
    chk({tag, " R10 den_n"}, den_n, 1);
    chk({tag, " R10 bhe_n"}, bhe_n, 1);
    chk({tag, " R10 ad_oe"}, ad_oe, 0);
    chk({tag, " R9 req_ready"}, req_ready, 1);
    chk({tag, " R1 cyc_done"}, cyc_done, 0);
  endtask

  task automatic drive_req(input vec_t v);
    req_valid  = 1'b1;
    req_write  = v.wr;
    req_addr   = v.addr;
    req_bhe    = v.bhe;
    req_status = v.stat;
    req_wdata  = v.wdata;
  endtask

  // Walks one cycle from T1A to T4B at negedges; returns at the T4B negedge.
  task automatic run_cycle(input vec_t v);
    int w, last;
    w = int'(v.waits);
    last = 7 + 2 * w;
    for (int idx = 0; idx <= last; idx++) begin
      logic oe_e, xf;
      if (idx == 0) req_valid = 1'b0;
      xf = (idx >= 3) && (idx <= 5 + 2 * w);
      oe_e = (idx <= 1) || (v.wr && idx >= 3);
      chk("R1 cyc_done", cyc_done, idx == last);
      chk("R9 req_ready", req_ready, idx == last);
      chk("R2 ale", ale, idx == 0);
      chk("R3 m_io", m_io, 1);
      chk("R3 dt_r", dt_r, v.wr);
      chk("R2 bhe_n", bhe_n, (idx <= 1) ? !v.bhe : 1'b1);
      chk(v.wr ? "R7 ad_oe" : "R5 ad_oe", ad_oe, oe_e);
      if (idx <= 1) chk("R2 ad_out", ad_out, v.addr[15:0]);
      else if (v.wr && idx >= 3) chk("R7 ad_out", ad_out, v.wdata);
      chk("R4 ahi_out", ahi_out, (idx <= 1) ? v.addr[19:16] : v.stat);
      chk("R5 rd_n", rd_n, !(!v.wr && xf));
      chk("R7 wr_n", wr_n, !(v.wr && idx >= 2 && idx <= 5 + 2 * w));
      chk("R5 R7 den_n", den_n, !(xf || (v.wr && idx == 6 + 2 * w)));
      if (idx == last) begin
        if (!v.wr) last_rd = v.rdata;
        chk("R6 rd_data", rd_data, last_rd);
      end
      // R8: ready low on the sample points inside the wait window
      bus_ready = !(idx >= 5 && idx < 5 + 2 * w);
      ad_in = (idx == 5 + 2 * w) ? v.rdata : ~v.rdata;
      if (idx != last) begin
        @(posedge clk);
        @(negedge clk);
      end
    end
    bus_ready = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("reset");
    chk("R10 rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].gap && i > 0) begin
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_idle("gap R9");
      end
      drive_req(VEC[i]);
      chk("R9 req_ready before accept", req_ready, 1);
      @(posedge clk);
      @(negedge clk);
      run_cycle(VEC[i]);
    end
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_idle("end of table");
    chk("R6 rd_data held in idle", rd_data, last_rd);

    // Reset during T2B of a read: strobes released at once.
    drive_req(VEC[0]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R5 rd_n low in T2B", rd_n, 0);
    rst_n = 1'b0;
    #1;
    chk_idle("mid-cycle reset");
    chk("R10 rd_data cleared", rd_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("recovered");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule